// File: doc/BRIEF.md
# Bidirectional Edge Counter with Threshold Flag

This block counts events from two sources into one signed accumulator. A rising transition on the increment input adds one. A rising transition on the decrement input takes one away. An input held high counts only once, because the block detects the transitions internally. One threshold value is shared by both directions. The done flag shows whether the running total has reached that threshold. Counting carries on past the threshold in either direction.

The accumulator is `WIDTH` bits wide in two's complement. The default of 16 gives the range −32768 to +32767. Stepping beyond either end wraps the value and raises a sticky flag for that end. A synchronous clear input has priority over both count inputs. It zeroes the total and drops both sticky flags. The clear is the way a surrounding controller restarts a batch.

Top module: `udc_counter`

## Requirements
- R1: On a clock edge where countUp is high and was low at the previous edge, accum increases by exactly one. Holding countUp high for further cycles adds nothing more.
- R2: On a clock edge where countDown is high and was low at the previous edge, accum decreases by exactly one. Holding it high adds nothing more.
- R3: When rising transitions of countUp and countDown are seen at the same clock edge, accum keeps its value.
- R4: done is 1 exactly when accum, read as signed, is greater than or equal to preset, also read as signed. Counting continues past preset without stopping.
- R5: done returns to 0 once decrements bring accum below preset.
- R6: When countReset is high at a clock edge, the next value is accum = 0, overflow = 0 and underflow = 0. This holds whatever the count inputs do at that edge.
- R7: An increment from the largest value (2^(WIDTH−1)−1) wraps accum to the smallest value (−2^(WIDTH−1)) and sets overflow. overflow then stays 1 until a clear.
- R8: A decrement from the smallest value wraps accum to the largest value and sets underflow. underflow then stays 1 until a clear.
- R9: While rstN is low, accum is 0 and overflow and underflow are 0. A count input that is already high when rstN rises counts as one rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| countUp | input | 1 | Increment event level |
| countDown | input | 1 | Decrement event level |
| countReset | input | 1 | Synchronous clear of the total and the flags; has priority |
| preset | input | WIDTH | Signed threshold for done |
| accum | output | WIDTH | Signed running total |
| done | output | 1 | Total is at or above the threshold |
| overflow | output | 1 | Sticky: an increment wrapped at the top |
| underflow | output | 1 | Sticky: a decrement wrapped at the bottom |

## Verification
The bench builds the counter with WIDTH = 6, so the range is −32 to +31. Both wrap points can then be reached in a few dozen transitions rather than tens of thousands. The narrow width also lets the bench walk the full positive span and the full negative span. At those points it checks the wrap values, the stickiness of both flags and the signed threshold compare with negative presets.

// File: rtl/udc_pkg.sv
package udc_pkg;
  // Per-cycle commands from the control stage to the datapath
  typedef struct packed {
    logic clear;
    logic inc;
    logic dec;
  } udc_strobe_t;

  localparam int unsigned NUM_SRC = 2;  // index 0: up, index 1: down
endpackage

// File: rtl/udc_ctrl.sv
module udc_ctrl
  import udc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        countUp,
  input  logic        countDown,
  input  logic        countReset,
  output udc_strobe_t strobe
);
  logic [NUM_SRC-1:0] rawIn;
  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] edgeHit;

  assign rawIn = {countDown, countUp};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevIn[g] <= 1'b0;
      else       prevIn[g] <= rawIn[g];
    end
    assign edgeHit[g] = rawIn[g] & ~prevIn[g];
  end

  always_comb begin
    strobe.clear = countReset;
    strobe.inc   = 1'b0;
    strobe.dec   = 1'b0;
    if (!countReset) begin
      // simultaneous transitions cancel
      strobe.inc = edgeHit[0] & ~edgeHit[1];
      strobe.dec = edgeHit[1] & ~edgeHit[0];
    end
  end
endmodule

// File: rtl/udc_dp.sv
module udc_dp
  import udc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  udc_strobe_t             strobe,
  input  logic signed [WIDTH-1:0] preset,
  output logic signed [WIDTH-1:0] accum,
  output logic                    done,
  output logic                    overflow,
  output logic                    underflow
);
  localparam logic signed [WIDTH-1:0] MAX_VAL = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic signed [WIDTH-1:0] ONE     = WIDTH'(1);

  logic atTop;
  logic atBottom;

  assign atTop    = (accum == MAX_VAL);
  assign atBottom = (accum == MIN_VAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (strobe.clear) begin
      accum     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (strobe.inc) begin
      accum <= accum + ONE;
      if (atTop) overflow <= 1'b1;
    end else if (strobe.dec) begin
      accum <= accum - ONE;
      if (atBottom) underflow <= 1'b1;
    end
  end

  assign done = (accum >= preset);
endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    countUp,
  input  logic                    countDown,
  input  logic                    countReset,
  input  logic signed [WIDTH-1:0] preset,
  output logic signed [WIDTH-1:0] accum,
  output logic                    done,
  output logic                    overflow,
  output logic                    underflow
);
  udc_strobe_t strobe;

  udc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .countUp    (countUp),
    .countDown  (countDown),
    .countReset (countReset),
    .strobe     (strobe)
  );

  udc_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .preset    (preset),
    .accum     (accum),
    .done      (done),
    .overflow  (overflow),
    .underflow (underflow)
  );
endmodule

// File: rtl/udc_counter_checker.sv
module udc_counter_checker #(
  parameter int WIDTH = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    countUp,
  input logic                    countDown,
  input logic                    countReset,
  input logic signed [WIDTH-1:0] preset,
  input logic signed [WIDTH-1:0] accum,
  input logic                    done,
  input logic                    overflow,
  input logic                    underflow
);
  localparam logic signed [WIDTH-1:0] TOP = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] BOT = {1'b1, {(WIDTH-1){1'b0}}};

  logic lastUp;
  logic lastDown;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastUp   <= 1'b0;
      lastDown <= 1'b0;
    end else begin
      lastUp   <= countUp;
      lastDown <= countDown;
    end
  end

  logic upRise;
  logic downRise;
  assign upRise   = countUp & ~lastUp;
  assign downRise = countDown & ~lastDown;

  assert_up_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (upRise && !downRise && !countReset && accum != TOP) |=> accum == WIDTH'($past(accum) + 1'b1));

  assert_down_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (downRise && !upRise && !countReset && accum != BOT) |=> accum == WIDTH'($past(accum) - 1'b1));

  assert_cancel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (upRise && downRise && !countReset) |=> $stable(accum));

  assert_done_at_preset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accum == preset) |-> done);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    countReset |=> (accum == '0 && !overflow && !underflow));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !countReset) |=> overflow);

  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !countReset) |=> underflow);
endmodule

bind udc_counter udc_counter_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .countUp    (countUp),
  .countDown  (countDown),
  .countReset (countReset),
  .preset     (preset),
  .accum      (accum),
  .done       (done),
  .overflow   (overflow),
  .underflow  (underflow)
);

// File: tb/udc_counter_bench.sv
module udc_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 6;
  localparam int MAXV       = 31;
  localparam int MINV       = -32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countUp = 1'b0;
  logic countDown = 1'b0;
  logic countReset = 1'b0;
  logic signed [WIDTH-1:0] preset = '0;
  logic signed [WIDTH-1:0] accum;
  logic done;
  logic overflow;
  logic underflow;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udc_counter #(.WIDTH(WIDTH)) u_udc_counter (
    .clk(clk), .rstN(rstN), .countUp(countUp), .countDown(countDown),
    .countReset(countReset), .preset(preset), .accum(accum), .done(done),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int accI();
    return int'(accum);
  endfunction

  // one rising transition on the chosen inputs, then release; ends at a negedge
  task automatic pulse(input logic u, input logic d);
    @(negedge clk);
    countUp = u; countDown = d;
    @(negedge clk);
    countUp = 1'b0; countDown = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearCount();
    @(negedge clk);
    countReset = 1'b1;
    @(negedge clk);
    countReset = 1'b0;
  endtask

  task automatic testReset();
    preset = 6'sd3;
    #1;
    chk("R9 accum in reset", accI(), 0);
    chk("R9 overflow in reset", int'(overflow), 0);
    chk("R9 underflow in reset", int'(underflow), 0);
    // countUp high across reset release counts once
    countUp = 1'b1;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 level at release", accI(), 1);
    countUp = 1'b0;
    @(negedge clk);
    chk("R4 done below preset", int'(done), 0);
  endtask

  task automatic testHeld();
    clearCount();
    @(negedge clk); countUp = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 held level counts once", accI(), 1);
    countUp = 1'b0;
    pulse(1'b1, 1'b0);
    chk("R1 second transition", accI(), 2);
  endtask

  task automatic testDown();
    @(negedge clk); countDown = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 held down counts once", accI(), 1);
    countDown = 1'b0;
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R2 below zero", accI(), -1);
  endtask

  task automatic testBoth();
    pulse(1'b1, 1'b1);
    chk("R3 simultaneous no change", accI(), -1);
  endtask

  task automatic testPreset();
    clearCount();
    preset = 6'sd3;
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    chk("R4 done at 2 of 3", int'(done), 0);
    pulse(1'b1, 1'b0);
    chk("R4 done at preset", int'(done), 1);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    chk("R4 count passes preset", accI(), 5);
    chk("R4 done above preset", int'(done), 1);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk("R5 done back at preset", int'(done), 1);
    pulse(1'b0, 1'b1);
    chk("R5 done below preset", int'(done), 0);
    preset = -6'sd2;
    clearCount();
    #1;
    chk("R4 negative preset signed", int'(done), 1);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk("R5 below negative preset", int'(done), 0);
  endtask

  task automatic testOverflow();
    clearCount();
    for (int i = 0; i < MAXV; i++) pulse(1'b1, 1'b0);
    chk("R7 at max", accI(), MAXV);
    chk("R7 no flag at max", int'(overflow), 0);
    pulse(1'b1, 1'b0);
    chk("R7 wrap to min", accI(), MINV);
    chk("R7 flag set", int'(overflow), 1);
    pulse(1'b1, 1'b0);
    chk("R7 flag sticky", int'(overflow), 1);
    chk("R7 count continues", accI(), MINV + 1);
  endtask

  task automatic testClear();
    // clear with a coincident up transition: clear wins
    @(negedge clk);
    countReset = 1'b1; countUp = 1'b1;
    @(negedge clk);
    countReset = 1'b0;
    chk("R6 accum cleared", accI(), 0);
    chk("R6 overflow cleared", int'(overflow), 0);
    @(negedge clk);
    countUp = 1'b0;
    @(negedge clk);
    chk("R6 held level after clear", accI(), 0);
  endtask

  task automatic testUnderflow();
    clearCount();
    for (int i = 0; i < -MINV; i++) pulse(1'b0, 1'b1);
    chk("R8 at min", accI(), MINV);
    chk("R8 no flag at min", int'(underflow), 0);
    pulse(1'b0, 1'b1);
    chk("R8 wrap to max", accI(), MAXV);
    chk("R8 flag set", int'(underflow), 1);
    pulse(1'b0, 1'b1);
    chk("R8 flag sticky", int'(underflow), 1);
    clearCount();
    chk("R6 underflow cleared", int'(underflow), 0);
  endtask

  initial begin
    testReset();
    testHeld();
    testDown();
    testBoth();
    testPreset();
    testOverflow();
    testClear();
    testUnderflow();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule